// File: doc/BRIEF.md
# Flash Erase Command Decoder with Status Register

This block sits between the host bus of a parallel flash device and its erase engine. It watches bus write cycles, each carrying an address and a data byte, and interprets them as commands. Erase of a main-array block and erase of the overlay block both take two write cycles: a setup byte written at address zero, then a confirm byte written inside the block to erase. A correct pair issues a start request to the engine. A wrong confirm ends the sequence with an error flag and no erase. While an erase runs, the block accepts only a narrow set of commands. A main-array erase can be suspended and resumed.

The block keeps an 8-bit status register. It holds a ready flag, a suspend flag, sticky erase, program and supply errors, and two overlay indications. The supply-valid flag is checked when the erase is confirmed and again while the erase runs. Dropping the active-low power-down pin aborts any active erase and returns the decoder to its idle state. A separate output tells the read path whether read cycles return the status register or array data.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status register reads 80h with overlay enable low, no engine strobe is active, and reads return array data (`rd_status` = 0). A reset during a half-entered sequence discards it, so a following D0h starts nothing.
- R2: Writing 20h at address 0 and then D0h at address A pulses `eng_start` for exactly one cycle, with `eng_overlay` = 0 and `eng_block_addr` = A. While the erase runs, status bit 7 reads 0.
- R3: 20h at a nonzero address is not a setup and selects array reads. After a valid 20h setup, any second write other than D0h sets status bits 5 and 4, returns the block to idle and issues no start.
- R4: Writing 02h at address 0 and then 0Dh at an address inside the overlay window (upper address bits equal to those of `OVL_BASE`, window of 2^`OVL_SPAN_LOG2` bytes) starts an erase with `eng_overlay` = 1. Any other second write sets only status bit 5 and starts nothing.
- R5: While a main erase runs, only 70h (status read) and B0h (suspend) act. Clear (50h), setup (20h) and all other bytes change neither status nor strobes.
- R6: While an overlay erase runs, only 70h is accepted. B0h and 50h have no effect on strobes or status.
- R7: B0h during a running main erase pulses `eng_suspend` once and makes status bits 7, 6 and 5 read 1. While suspended, writes other than D0h are ignored. D0h pulses `eng_resume` once, and bits 6 and 5 then read 0 again unless an erase error was already recorded.
- R8: If the supply is not valid when D0h confirms a main erase, status bit 3 is set and no start is issued. If the supply becomes invalid while an erase runs, bit 3 is set and `eng_abort` pulses once.
- R9: With `rp_n` low, a running or suspended erase is aborted (`eng_abort` pulses once), status bits 5 to 3 clear, reads return array data and write cycles are ignored.
- R10: When the engine signals done with fail high, status bit 5 is set and bit 7 returns to 1. Done without fail leaves bit 5 unchanged.
- R11: Status bits 5, 4 and 3 are sticky. A new erase sequence keeps them, and only 50h written outside a running or suspended erase clears them.
- R12: Status bit 1 equals `ovl_en`, and bit 0 reads 1 only when `ovl_en` and `vpp_ok` are both high. Bit 2 is always 0.
- R13: After a 70h or after any erase setup, reads return status (`rd_status` = 1). Any unrecognised byte written while idle selects array reads.
- R14: Status bit 7 also reads 0 while `eng_busy` is high outside a suspend, for example while the engine winds down after an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rp_n | input | 1 | Active-low reset/power-down pin, sampled on the clock |
| wr_en | input | 1 | Bus write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the write cycle |
| wr_data | input | 8 | Command byte of the write cycle |
| vpp_ok | input | 1 | Program/erase supply is within range |
| ovl_en | input | 1 | Overlay block is enabled |
| eng_busy | input | 1 | Erase engine is active |
| eng_done | input | 1 | Erase engine finished, one-cycle pulse |
| eng_fail | input | 1 | Qualifies eng_done: the erase failed |
| eng_start | output | 1 | Start-erase strobe |
| eng_overlay | output | 1 | Last started erase targets the overlay block |
| eng_block_addr | output | ADDR_W | Address captured with the confirm byte |
| eng_suspend | output | 1 | Suspend strobe |
| eng_resume | output | 1 | Resume strobe |
| eng_abort | output | 1 | Abort strobe |
| rd_status | output | 1 | Read cycles return the status register |
| status | output | 8 | Status register |

## Verification
The bench targets the confirm cycle. A decoder that checked only the data byte would start an overlay erase from a 0Dh written outside the window. One that cleared the error bits on a new setup would lose the sticky erase failure. The restricted windows come next: a clear or a fresh setup accepted mid-erase would wipe status or restart the engine, and a suspend honoured during an overlay erase would emit a strobe that must never occur. The bench also drops the supply and the power-down pin during a running erase, and checks the write ignored while the pin is low. A design that merely paused here, or still latched that write, would later start an erase from a stray confirm byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_OVL_SETUP   = 8'h02;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_OVL_CONFIRM = 8'h0D;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_CLEAR       = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP_MAIN = 3'd1,
    ST_SETUP_OVL  = 3'd2,
    ST_RUN_MAIN   = 3'd3,
    ST_RUN_OVL    = 3'd4,
    ST_SUSP       = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic erase_setup;
    logic ovl_setup;
    logic confirm;
    logic ovl_confirm;
    logic suspend;
    logic status;
    logic clear;
  } cmd_t;

  typedef struct packed {
    logic bad_main;
    logic bad_ovl;
    logic vpp_err;
    logic fail;
    logic clear;
    logic wipe;
  } stat_ev_t;

endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = shift_q[STAGES-1];

endmodule

// File: rtl/fcd_decode.sv
module fcd_decode
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W        = 20,
  parameter logic [ADDR_W-1:0] OVL_BASE      = 20'hFF000,
  parameter int                OVL_SPAN_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cmd_t              cmd
);

  logic at_zero;
  logic in_ovl;

  assign at_zero = (wr_addr == '0);
  assign in_ovl  = (wr_addr[ADDR_W-1:OVL_SPAN_LOG2] == OVL_BASE[ADDR_W-1:OVL_SPAN_LOG2]);

  always_comb begin
    cmd             = '0;
    cmd.erase_setup = (wr_data == OP_ERASE_SETUP) && at_zero;
    cmd.ovl_setup   = (wr_data == OP_OVL_SETUP) && at_zero;
    cmd.confirm     = (wr_data == OP_CONFIRM);
    cmd.ovl_confirm = (wr_data == OP_OVL_CONFIRM) && in_ovl;
    cmd.suspend     = (wr_data == OP_SUSPEND);
    cmd.status      = (wr_data == OP_STATUS);
    cmd.clear       = (wr_data == OP_CLEAR);
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              wr_valid,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              vpp_ok,
  input  logic              pd,
  input  logic              eng_done,
  input  logic              eng_fail,
  output seq_state_e        state_o,
  output logic              eng_start,
  output logic              eng_suspend,
  output logic              eng_resume,
  output logic              eng_abort,
  output logic              eng_overlay,
  output logic [ADDR_W-1:0] eng_block_addr,
  output logic              rd_status,
  output stat_ev_t          ev
);

  seq_state_e        state_q, state_d;
  logic              start_q, start_d;
  logic              susp_q, susp_d;
  logic              res_q, res_d;
  logic              abort_q, abort_d;
  logic              ovl_q, ovl_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              active;

  assign active = (state_q == ST_RUN_MAIN) || (state_q == ST_RUN_OVL) ||
                  (state_q == ST_SUSP);

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    susp_d  = 1'b0;
    res_d   = 1'b0;
    abort_d = 1'b0;
    ovl_d   = ovl_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    ev      = '0;
    if (pd) begin
      abort_d = active;
      state_d = ST_IDLE;
      rd_d    = 1'b0;
      ev.wipe = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_valid) begin
            if (cmd.erase_setup) begin
              state_d = ST_SETUP_MAIN;
              rd_d    = 1'b1;
            end else if (cmd.ovl_setup) begin
              state_d = ST_SETUP_OVL;
              rd_d    = 1'b1;
            end else if (cmd.status) begin
              rd_d = 1'b1;
            end else if (cmd.clear) begin
              ev.clear = 1'b1;
            end else begin
              rd_d = 1'b0;
            end
          end
        end
        ST_SETUP_MAIN: begin
          if (wr_valid) begin
            state_d = ST_IDLE;
            if (!cmd.confirm) begin
              ev.bad_main = 1'b1;
            end else if (!vpp_ok) begin
              ev.vpp_err = 1'b1;
            end else begin
              state_d = ST_RUN_MAIN;
              start_d = 1'b1;
              ovl_d   = 1'b0;
              addr_d  = wr_addr;
            end
          end
        end
        ST_SETUP_OVL: begin
          if (wr_valid) begin
            state_d = ST_IDLE;
            if (!cmd.ovl_confirm) begin
              ev.bad_ovl = 1'b1;
            end else if (!vpp_ok) begin
              ev.vpp_err = 1'b1;
            end else begin
              state_d = ST_RUN_OVL;
              start_d = 1'b1;
              ovl_d   = 1'b1;
              addr_d  = wr_addr;
            end
          end
        end
        ST_RUN_MAIN, ST_RUN_OVL: begin
          if (!vpp_ok) begin
            ev.vpp_err = 1'b1;
            abort_d    = 1'b1;
            state_d    = ST_IDLE;
          end else if (eng_done) begin
            ev.fail = eng_fail;
            state_d = ST_IDLE;
          end else if (wr_valid && cmd.suspend && (state_q == ST_RUN_MAIN)) begin
            susp_d  = 1'b1;
            state_d = ST_SUSP;
          end
        end
        ST_SUSP: begin
          if (wr_valid && cmd.confirm) begin
            res_d   = 1'b1;
            state_d = ST_RUN_MAIN;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      susp_q  <= 1'b0;
      res_q   <= 1'b0;
      abort_q <= 1'b0;
      ovl_q   <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      susp_q  <= susp_d;
      res_q   <= res_d;
      abort_q <= abort_d;
      ovl_q   <= ovl_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
    end
  end

  assign state_o        = state_q;
  assign eng_start      = start_q;
  assign eng_suspend    = susp_q;
  assign eng_resume     = res_q;
  assign eng_abort      = abort_q;
  assign eng_overlay    = ovl_q;
  assign eng_block_addr = addr_q;
  assign rd_status      = rd_q;

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({start_q, susp_q, res_q, abort_q}));

  assert_start_enters_run_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    start_q |-> ((state_q == ST_RUN_MAIN) || (state_q == ST_RUN_OVL)));

  assert_suspend_main_only_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    susp_q |-> ((state_q == ST_SUSP) && !ovl_q));

  assert_pd_aborts_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (pd && active) |=> (abort_q && (state_q == ST_IDLE)));

  assert_pd_no_start_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    pd |=> (!start_q && !rd_q));

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ns,
  input  stat_ev_t ev,
  input  logic     running,
  input  logic     suspended,
  input  logic     eng_busy,
  input  logic     ovl_en,
  input  logic     vpp_ok,
  output logic [7:0] status_o
);

  logic es_q, es_d;
  logic ps_q, ps_d;
  logic vpp_q, vpp_d;
  logic ready;

  always_comb begin
    es_d  = es_q;
    ps_d  = ps_q;
    vpp_d = vpp_q;
    if (ev.clear || ev.wipe) begin
      es_d  = 1'b0;
      ps_d  = 1'b0;
      vpp_d = 1'b0;
    end else begin
      if (ev.bad_main || ev.bad_ovl || ev.fail) es_d  = 1'b1;
      if (ev.bad_main)                          ps_d  = 1'b1;
      if (ev.vpp_err)                           vpp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      es_q  <= 1'b0;
      ps_q  <= 1'b0;
      vpp_q <= 1'b0;
    end else begin
      es_q  <= es_d;
      ps_q  <= ps_d;
      vpp_q <= vpp_d;
    end
  end

  assign ready    = !(running || (eng_busy && !suspended));
  assign status_o = {ready, suspended, es_q | suspended, ps_q, vpp_q,
                     1'b0, ovl_en, ovl_en & vpp_ok};

  assert_vpp_flag_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    ev.vpp_err |=> status_o[3]);

  assert_clear_bits_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (ev.clear || ev.wipe) |=> (status_o[5:3] == 3'b000));

  assert_ps_sticky_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (status_o[4] && !ev.clear && !ev.wipe) |=> status_o[4]);

  assert_ovl_active_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    status_o[0] |-> (status_o[1] && !status_o[2]));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W        = 20,
  parameter logic [ADDR_W-1:0] OVL_BASE      = 20'hFF000,
  parameter int                OVL_SPAN_LOG2 = 12,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_ok,
  input  logic              ovl_en,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              eng_start,
  output logic              eng_overlay,
  output logic [ADDR_W-1:0] eng_block_addr,
  output logic              eng_suspend,
  output logic              eng_resume,
  output logic              eng_abort,
  output logic              rd_status,
  output logic [7:0]        status
);

  logic       rst_ns;
  logic       pd;
  logic       wr_valid;
  cmd_t       cmd;
  stat_ev_t   ev;
  seq_state_e state;
  logic       running;
  logic       suspended;

  assign pd        = !rp_n;
  assign wr_valid  = wr_en && rp_n;
  assign running   = (state == ST_RUN_MAIN) || (state == ST_RUN_OVL);
  assign suspended = (state == ST_SUSP);

  fcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_ns (rst_ns)
  );

  fcd_decode #(
    .ADDR_W        (ADDR_W),
    .OVL_BASE      (OVL_BASE),
    .OVL_SPAN_LOG2 (OVL_SPAN_LOG2)
  ) u_dec (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk            (clk),
    .rst_ns         (rst_ns),
    .wr_valid       (wr_valid),
    .cmd            (cmd),
    .wr_addr        (wr_addr),
    .vpp_ok         (vpp_ok),
    .pd             (pd),
    .eng_done       (eng_done),
    .eng_fail       (eng_fail),
    .state_o        (state),
    .eng_start      (eng_start),
    .eng_suspend    (eng_suspend),
    .eng_resume     (eng_resume),
    .eng_abort      (eng_abort),
    .eng_overlay    (eng_overlay),
    .eng_block_addr (eng_block_addr),
    .rd_status      (rd_status),
    .ev             (ev)
  );

  fcd_status u_stat (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .ev        (ev),
    .running   (running),
    .suspended (suspended),
    .eng_busy  (eng_busy),
    .ovl_en    (ovl_en),
    .vpp_ok    (vpp_ok),
    .status_o  (status)
  );

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int AW = 20;
  localparam int WATCHDOG = 20000;
  localparam int NVEC = 34;

  logic          clk = 1'b0;
  logic          rst_n, rp_n, wr_en, vpp_ok, ovl_en, eng_busy, eng_done, eng_fail;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          eng_start, eng_overlay, eng_suspend, eng_resume, eng_abort, rd_status;
  logic [AW-1:0] eng_block_addr;
  logic [7:0]    status;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vpp_ok(vpp_ok), .ovl_en(ovl_en), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_fail(eng_fail), .eng_start(eng_start),
    .eng_overlay(eng_overlay), .eng_block_addr(eng_block_addr),
    .eng_suspend(eng_suspend), .eng_resume(eng_resume), .eng_abort(eng_abort),
    .rd_status(rd_status), .status(status)
  );

  // {kind, data, addr, status, strobes{start,susp,res,abort}, rd, ovl, req}
  // kind: 0 write, 1 done ok, 2 done fail
  localparam logic [47:0] VEC [0:NVEC-1] = '{
    {2'd0, 8'h70, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd13}, // R13 status mode
    {2'd0, 8'hFF, 20'h00000, 8'h80, 4'h0, 1'b0, 1'b0, 4'd13}, // R13 array mode
    {2'd0, 8'h20, 20'h00004, 8'h80, 4'h0, 1'b0, 1'b0, 4'd3},  // R3 setup off zero
    {2'd0, 8'h20, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd2},  // R2 setup
    {2'd0, 8'h30, 20'h10000, 8'hB0, 4'h0, 1'b1, 1'b0, 4'd3},  // R3 bad confirm
    {2'd0, 8'h50, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd11}, // R11 clear
    {2'd0, 8'h02, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd4},  // R4 ovl setup
    {2'd0, 8'hD0, 20'hFF010, 8'hA0, 4'h0, 1'b1, 1'b0, 4'd4},  // R4 wrong byte
    {2'd0, 8'h50, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd11}, // R11
    {2'd0, 8'h02, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd4},  // R4
    {2'd0, 8'h0D, 20'h00100, 8'hA0, 4'h0, 1'b1, 1'b0, 4'd4},  // R4 outside window
    {2'd0, 8'h50, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd11}, // R11
    {2'd0, 8'h20, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd2},  // R2
    {2'd0, 8'hD0, 20'h12345, 8'h00, 4'h8, 1'b1, 1'b0, 4'd2},  // R2 start
    {2'd0, 8'h50, 20'h00000, 8'h00, 4'h0, 1'b1, 1'b0, 4'd5},  // R5 clear ignored
    {2'd0, 8'h20, 20'h00000, 8'h00, 4'h0, 1'b1, 1'b0, 4'd5},  // R5 setup ignored
    {2'd0, 8'hB0, 20'h00000, 8'hE0, 4'h4, 1'b1, 1'b0, 4'd7},  // R7 suspend
    {2'd0, 8'h50, 20'h00000, 8'hE0, 4'h0, 1'b1, 1'b0, 4'd7},  // R7 ignored
    {2'd0, 8'hD0, 20'h00000, 8'h00, 4'h2, 1'b1, 1'b0, 4'd7},  // R7 resume
    {2'd0, 8'h70, 20'h00000, 8'h00, 4'h0, 1'b1, 1'b0, 4'd5},  // R5 status ok
    {2'd1, 8'h00, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd10}, // R10 done ok
    {2'd0, 8'h20, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd2},  // R2
    {2'd0, 8'hD0, 20'h23456, 8'h00, 4'h8, 1'b1, 1'b0, 4'd2},  // R2
    {2'd2, 8'h00, 20'h00000, 8'hA0, 4'h0, 1'b1, 1'b0, 4'd10}, // R10 done fail
    {2'd0, 8'h20, 20'h00000, 8'hA0, 4'h0, 1'b1, 1'b0, 4'd11}, // R11 sticky
    {2'd0, 8'hD0, 20'h34567, 8'h20, 4'h8, 1'b1, 1'b0, 4'd11}, // R11 sticky run
    {2'd1, 8'h00, 20'h00000, 8'hA0, 4'h0, 1'b1, 1'b0, 4'd10}, // R10 ok keeps bit 5
    {2'd0, 8'h50, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd11}, // R11
    {2'd0, 8'h02, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b0, 4'd4},  // R4
    {2'd0, 8'h0D, 20'hFF800, 8'h00, 4'h8, 1'b1, 1'b1, 4'd4},  // R4 ovl start
    {2'd0, 8'hB0, 20'h00000, 8'h00, 4'h0, 1'b1, 1'b1, 4'd6},  // R6 no suspend
    {2'd0, 8'h50, 20'h00000, 8'h00, 4'h0, 1'b1, 1'b1, 4'd6},  // R6 no clear
    {2'd1, 8'h00, 20'h00000, 8'h80, 4'h0, 1'b1, 1'b1, 4'd6},  // R6 finish
    {2'd0, 8'hFF, 20'h00000, 8'h80, 4'h0, 1'b0, 1'b1, 4'd13}  // R13
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [3:0] strobes();
    return {eng_start, eng_suspend, eng_resume, eng_abort};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rp_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vpp_ok = 1'b1; ovl_en = 1'b0; eng_busy = 1'b0; eng_done = 1'b0; eng_fail = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1", "status", status, 8'h80);
    chk("R1", "strobes", strobes(), 4'h0);
    chk("R1", "rd_status", rd_status, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[3:0], i);
      if (v[47:46] == 2'd0) begin
        wr(v[45:38], v[37:18]);
      end else begin
        @(negedge clk);
        eng_done = 1'b1; eng_fail = (v[47:46] == 2'd2);
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
      end
      checks++;
      if (status !== v[17:10] || strobes() !== v[9:6] ||
          rd_status !== v[5] || eng_overlay !== v[4]) begin
        fails++;
        $display("FAIL %s: actual st=%h stb=%h rd=%b ovl=%b expected st=%h stb=%h rd=%b ovl=%b",
                 rq, status, strobes(), rd_status, eng_overlay,
                 v[17:10], v[9:6], v[5], v[4]);
      end
    end

    // R12 overlay indications
    ovl_en = 1'b1;
    @(negedge clk);
    chk("R12", "status ovl+vpp", status, 8'h83);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R12", "status ovl no vpp", status, 8'h82);
    vpp_ok = 1'b1; ovl_en = 1'b0;

    // R8 supply invalid at confirm
    vpp_ok = 1'b0;
    wr(8'h20, 20'h0);
    wr(8'hD0, 20'h11111);
    chk("R8", "status at bad supply", status, 8'h88);
    chk("R8", "no start", strobes(), 4'h0);
    vpp_ok = 1'b1;
    wr(8'h50, 20'h0);
    // R8 supply drop during erase
    wr(8'h20, 20'h0);
    wr(8'hD0, 20'h22222);
    chk("R8", "start", strobes(), 4'h8);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R8", "abort on drop", strobes(), 4'h1);
    chk("R8", "status on drop", status, 8'h88);
    vpp_ok = 1'b1;
    wr(8'h50, 20'h0);

    // R9 power-down during erase, with R2 address capture and R14 busy
    wr(8'h20, 20'h0);
    wr(8'h30, 20'h0);
    wr(8'h20, 20'h0);
    wr(8'hD0, 20'h3ABCD);
    chk("R2", "block addr", eng_block_addr, 20'h3ABCD);
    chk("R2", "main select", eng_overlay, 1'b0);
    eng_busy = 1'b1;
    chk("R11", "sticky while running", status, 8'h30);
    rp_n = 1'b0;
    @(negedge clk);
    chk("R9", "abort strobe", strobes(), 4'h1);
    chk("R14", "busy holds ready low", status, 8'h00);
    chk("R9", "array reads", rd_status, 1'b0);
    wr(8'h20, 20'h0);
    rp_n = 1'b1; eng_busy = 1'b0;
    wr(8'hD0, 20'h0);
    chk("R9", "ignored write starts nothing", strobes(), 4'h0);
    chk("R9", "status after pd", status, 8'h80);

    // R1 reset discards a pending setup
    wr(8'h20, 20'h0);
    do_reset();
    chk("R1", "status after reset", status, 8'h80);
    chk("R1", "rd after reset", rd_status, 1'b0);
    wr(8'hD0, 20'h0);
    chk("R1", "no start after reset", strobes(), 4'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule